// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link placed in front of a small random-access byte memory (16K bytes with the default parameters). It oversamples the serial clock, chip select, data-in and hold pins with the system clock. It decodes one command byte for each period in which chip select is low, and then handles what follows the command byte. For the memory commands, that is a 16-bit big-endian address followed by a stream of data bytes that runs without limit. The address advances by one after every byte and wraps from the top of the array back to zero.

Memory bytes go to a synchronous RAM through an address, a write-data bus, a write strobe and a read strobe. Each write is gated by a permit flag from an external protection unit, which looks at the presented address. The status byte is also owned outside the block: it is read from `status_in`, and a write of it leaves as a strobe gated by a second permit flag. The write-enable set and clear commands and the sleep and wake commands leave as one-cycle strobes for the protection and power logic. A hold pin freezes a transaction in place and floats the data output until hold is released.

Top module: `spi_mem_slave`

## Requirements
- R1: Opcode 06h pulses `wel_set`, 04h pulses `wel_clr`, B9h pulses `sleep_req` and ABh pulses `wake_req`, each for one clock after the eighth bit of the opcode.
- R2: Opcode 03h is followed by a 16-bit address sent MSB first, of which bits 15:14 are ignored. The byte at that address then appears on `so` MSB first. Bit 7 is driven after the falling SCK edge that follows the 24th rising edge, and each later bit is driven after the next falling edge.
- R3: In both the read stream and the write stream the address increments after each byte, wrapping from 3FFFh to 0000h, until chip select rises.
- R4: Opcode 02h plus a 16-bit address starts a write stream. Each fully received byte produces one `mem_we` pulse at the current address, and only if `wr_allow` is high for that address. A partial byte at chip-select rise writes nothing.
- R5: `so_oe` is low after reset, while chip select is high, while hold is low, and during any command that sends no data back.
- R6: After a command has executed, further bytes in the same chip-select period are ignored. An opcode outside the command set produces no strobe and no output until chip select rises.
- R7: While `hold_n` is low, SCK edges and chip-select changes are ignored. After release, the bit stream resumes at the bit where it stopped.
- R8: Opcode 05h returns `status_in` MSB first, starting at the falling edge after the opcode. Every further byte period returns a fresh copy.
- R9: Opcode 01h followed by a full data byte pulses `sr_we` with that byte on `sr_wdata`, only if `sr_wr_allow` is high. Fewer than 8 data bits produce no pulse.
- R10: SI is sampled on rising SCK edges and SO changes on falling edges, whether SCK idles low (mode 0) or high (mode 3) when chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low hold; freezes the transaction |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write strobe, already gated by `wr_allow` |
| mem_re | output | 1 | RAM read strobe; data expected one clock later |
| mem_rdata | input | 8 | RAM read data |
| wr_allow | input | 1 | Protection permit for a write at `mem_addr` |
| status_in | input | 8 | Status byte returned by opcode 05h |
| sr_wr_allow | input | 1 | Protection permit for a status write |
| sr_wdata | output | 8 | New status byte |
| sr_we | output | 1 | Status write strobe, already gated by `sr_wr_allow` |
| wel_set | output | 1 | Write-enable set strobe |
| wel_clr | output | 1 | Write-enable clear strobe |
| sleep_req | output | 1 | Sleep entry strobe to the power block |
| wake_req | output | 1 | Sleep exit strobe to the power block |

## Verification
The bench builds the block with its defaults: a 14-bit address and two synchronizer stages, with SCK half periods of eight system clocks. With the full 14-bit array, the 3FFFh-to-0000h wrap and the ignored top address bits can be reached with a few bytes. The short synchronizer leaves enough margin that the read data fetched after the last address bit is in the shifter before the next falling edge. The protection model denies writes above a movable limit, so a single write stream can cross from permitted to refused addresses.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes and the transaction phase type of the serial memory front end.
package spi_mem_pkg;

    localparam logic [7:0] CMD_WEL_SET = 8'h06;
    localparam logic [7:0] CMD_WEL_CLR = 8'h04;
    localparam logic [7:0] CMD_SR_RD   = 8'h05;
    localparam logic [7:0] CMD_SR_WR   = 8'h01;
    localparam logic [7:0] CMD_READ    = 8'h03;
    localparam logic [7:0] CMD_WRITE   = 8'h02;
    localparam logic [7:0] CMD_SLEEP   = 8'hB9;
    localparam logic [7:0] CMD_WAKE    = 8'hAB;

    // Where the current chip-select period stands.
    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_RD_STREAM,
        PH_WR_STREAM,
        PH_SR_WRITE,
        PH_SR_READ,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer bank for asynchronous pins.
// Assumes each pin is held for several clocks, so that a bit-wise
// synchronizer is enough; the reset value of each bit is its idle level.
module spi_in_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the pin through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_so_drive.sv
// Output shifter: holds the byte being sent and moves one bit onto SO per
// shift request. The enable rises with the first shifted bit and stays on
// until deselect. Assumes load and shift never occur in the same clock.
module spi_so_drive (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       shift,
    input  logic       sel,
    input  logic       hold_ok,
    output logic       so,
    output logic       so_oe
);

    logic [7:0] txr;
    logic       so_q;
    logic       drive_en;

    // Load a new byte or shift its MSB onto the output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txr      <= '0;
            so_q     <= 1'b0;
            drive_en <= 1'b0;
        end else begin
            if (load) begin
                txr <= load_data;
            end else if (shift) begin
                so_q <= txr[7];
                txr  <= {txr[6:0], 1'b0};
            end
            if (shift)     drive_en <= 1'b1;
            else if (!sel) drive_en <= 1'b0;
        end
    end

    assign so    = so_q;
    assign so_oe = drive_en & sel & hold_ok;

    // A byte must be loaded before the next falling SCK edge asks for it.
    assert_no_load_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/spi_mem_core.sv
// Command engine. Detects SCK edges on synchronized pins and assembles bytes
// on rising edges. Decodes one opcode per selection and runs the address and
// data phases. It issues registered RAM, status and strobe requests, and
// feeds the output shifter.
// Assumes the SCK half period is at least 4 clocks, so that read data fetched
// after a rising edge is loaded before the following falling edge.
module spi_mem_core
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              si_s,
    input  logic              hold_s,
    input  logic [7:0]        status_in,
    input  logic [7:0]        mem_rdata,
    output logic              sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    output logic              wr_req,
    output logic              sr_req,
    output logic [7:0]        sr_wdata,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              sleep_req,
    output logic              wake_req,
    output logic              tx_load,
    output logic [7:0]        tx_data,
    output logic              tx_shift
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    logic              sck_d;
    logic [2:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic              rd_mode;
    logic              rd_pend;
    phase_e            phase;

    logic       live, rise_ok, fall_ok;
    logic [7:0] byte_in;

    assign live     = sel & hold_s;
    assign rise_ok  = live & sck_s & ~sck_d;
    assign fall_ok  = live & ~sck_s & sck_d;
    assign byte_in  = {shreg[6:0], si_s};
    assign tx_shift = fall_ok && (phase == PH_RD_STREAM || phase == PH_SR_READ);

    // Track the previous SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Selection, bit assembly, command decode and stream sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel       <= 1'b0;
            bitcnt    <= '0;
            shreg     <= '0;
            addr_hi   <= '0;
            ptr       <= '0;
            rd_mode   <= 1'b0;
            rd_pend   <= 1'b0;
            phase     <= PH_OPCODE;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_re    <= 1'b0;
            wr_req    <= 1'b0;
            sr_req    <= 1'b0;
            sr_wdata  <= '0;
            wel_set   <= 1'b0;
            wel_clr   <= 1'b0;
            sleep_req <= 1'b0;
            wake_req  <= 1'b0;
            tx_load   <= 1'b0;
            tx_data   <= '0;
        end else begin
            mem_re    <= 1'b0;
            wr_req    <= 1'b0;
            sr_req    <= 1'b0;
            wel_set   <= 1'b0;
            wel_clr   <= 1'b0;
            sleep_req <= 1'b0;
            wake_req  <= 1'b0;
            tx_load   <= 1'b0;
            rd_pend   <= mem_re;
            if (rd_pend) begin
                tx_load <= 1'b1;
                tx_data <= mem_rdata;
            end
            if (hold_s) sel <= ~cs_n_s;
            if (hold_s && cs_n_s) begin
                phase  <= PH_OPCODE;
                bitcnt <= '0;
            end else if (rise_ok) begin
                shreg  <= byte_in;
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    case (phase)
                        PH_OPCODE: begin
                            phase <= PH_DONE;
                            case (byte_in)
                                CMD_WEL_SET: wel_set   <= 1'b1;
                                CMD_WEL_CLR: wel_clr   <= 1'b1;
                                CMD_SLEEP:   sleep_req <= 1'b1;
                                CMD_WAKE:    wake_req  <= 1'b1;
                                CMD_SR_RD: begin
                                    tx_load <= 1'b1;
                                    tx_data <= status_in;
                                    phase   <= PH_SR_READ;
                                end
                                CMD_SR_WR: phase <= PH_SR_WRITE;
                                CMD_READ: begin
                                    rd_mode <= 1'b1;
                                    phase   <= PH_ADDR_HI;
                                end
                                CMD_WRITE: begin
                                    rd_mode <= 1'b0;
                                    phase   <= PH_ADDR_HI;
                                end
                                default: ;
                            endcase
                        end
                        PH_ADDR_HI: begin
                            addr_hi <= byte_in;
                            phase   <= PH_ADDR_LO;
                        end
                        PH_ADDR_LO: begin
                            ptr      <= ADDR_W'({addr_hi, byte_in});
                            mem_addr <= ADDR_W'({addr_hi, byte_in});
                            mem_re   <= rd_mode;
                            phase    <= rd_mode ? PH_RD_STREAM : PH_WR_STREAM;
                        end
                        PH_RD_STREAM: begin
                            ptr      <= ptr + ADDR_ONE;
                            mem_addr <= ptr + ADDR_ONE;
                            mem_re   <= 1'b1;
                        end
                        PH_WR_STREAM: begin
                            mem_addr  <= ptr;
                            mem_wdata <= byte_in;
                            wr_req    <= 1'b1;
                            ptr       <= ptr + ADDR_ONE;
                        end
                        PH_SR_WRITE: begin
                            sr_wdata <= byte_in;
                            sr_req   <= 1'b1;
                            phase    <= PH_DONE;
                        end
                        PH_SR_READ: begin
                            tx_load <= 1'b1;
                            tx_data <= status_in;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Checker state: address of the previous read fetch in this selection.
    logic [ADDR_W-1:0] chk_last_re;
    logic              chk_re_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last_re <= '0;
            chk_re_seen <= 1'b0;
        end else if (!sel) begin
            chk_re_seen <= 1'b0;
        end else if (mem_re) begin
            chk_last_re <= mem_addr;
            chk_re_seen <= 1'b1;
        end
    end

    assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && chk_re_seen) |-> (mem_addr == chk_last_re + ADDR_ONE));

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && $past(phase) == PH_DONE)
            |-> !(wel_set || wel_clr || sleep_req || wake_req || sr_req));

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> ($stable(bitcnt) && $stable(phase)));

endmodule

// File: rtl/spi_mem_slave.sv
// Top of the serial memory front end. Synchronizes the pins, runs the command
// engine and the output shifter, and gates memory and status writes with the
// permits of the external protection unit.
// Assumes a RAM that returns data one clock after mem_re, and an SCK half
// period of at least SYNC_STAGES + 2 system clocks.
module spi_mem_slave #(
    parameter int ADDR_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_allow,
    input  logic [7:0]        status_in,
    input  logic              sr_wr_allow,
    output logic [7:0]        sr_wdata,
    output logic              sr_we,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              sleep_req,
    output logic              wake_req
);

    localparam int         PIN_W   = 4;
    localparam logic [3:0] PIN_IDLE = 4'b1100;  // hold_n, cs_n, si, sck

    logic [PIN_W-1:0] pins_s;
    logic             sel, wr_req, sr_req, tx_load, tx_shift;
    logic [7:0]       tx_data;

    spi_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hold_n, cs_n, si, sck}),
        .q     (pins_s)
    );

    spi_mem_core #(.ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[0]),
        .cs_n_s    (pins_s[2]),
        .si_s      (pins_s[1]),
        .hold_s    (pins_s[3]),
        .status_in (status_in),
        .mem_rdata (mem_rdata),
        .sel       (sel),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .wr_req    (wr_req),
        .sr_req    (sr_req),
        .sr_wdata  (sr_wdata),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .tx_shift  (tx_shift)
    );

    spi_so_drive u_so (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (tx_data),
        .shift     (tx_shift),
        .sel       (sel),
        .hold_ok   (pins_s[3]),
        .so        (so),
        .so_oe     (so_oe)
    );

    assign mem_we = wr_req & wr_allow;
    assign sr_we  = sr_req & sr_wr_allow;

    assert_hiz_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[2] && pins_s[3]) |=> !so_oe);

endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;

    localparam int AW    = 14;
    localparam int DEPTH = 1 << AW;
    localparam int H     = 8;   // SCK half period in system clocks

    logic clk = 1'b0;
    logic rst_n, sck, cs_n, si, hold_n;
    logic so, so_oe, mem_we, mem_re, wr_allow, sr_wr_allow, sr_we;
    logic wel_set, wel_clr, sleep_req, wake_req;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, status_in, sr_wdata;
    logic [14:0] prot_limit;

    logic [7:0] ram    [DEPTH];
    logic [7:0] golden [DEPTH];

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    spi_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .wr_allow(wr_allow),
        .status_in(status_in), .sr_wr_allow(sr_wr_allow), .sr_wdata(sr_wdata),
        .sr_we(sr_we), .wel_set(wel_set), .wel_clr(wel_clr),
        .sleep_req(sleep_req), .wake_req(wake_req)
    );

    // Protection model and synchronous RAM model.
    assign wr_allow = ({1'b0, mem_addr} < prot_limit);
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [7:0] kind, input logic [15:0] a,
                             input logic [7:0] d, input string tag);
        exp_q.push_back({kind, a, d});
        tag_q.push_back(tag);
    endtask

    task automatic observe(input logic [31:0] ev);
        if (exp_q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL unexpected event actual=%h expected=none (R1 R4 R6 R9)", ev);
        end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, ev, e);
        end
    endtask

    // Monitor: compare every strobe against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wel_set)   observe({8'd1, 16'd0, 8'd0});
            if (wel_clr)   observe({8'd2, 16'd0, 8'd0});
            if (sleep_req) observe({8'd3, 16'd0, 8'd0});
            if (wake_req)  observe({8'd4, 16'd0, 8'd0});
            if (mem_we)    observe({8'd5, 2'b00, mem_addr, mem_wdata});
            if (sr_we)     observe({8'd6, 16'd0, sr_wdata});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_begin(input bit m3);
        sck = m3;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic sel_end(input bit m3);
        if (!m3) begin
            sck = 1'b0;
            tick(H);
        end
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    // Send the top n bits of d MSB first; return SO and its enable per bit.
    task automatic bits(input logic [7:0] d, input int n,
                        output logic [7:0] q, output logic [7:0] oe);
        q  = '0;
        oe = '0;
        for (int k = 0; k < n; k++) begin
            sck = 1'b0;
            si  = d[7-k];
            tick(H);
            q  = {q[6:0], so};
            oe = {oe[6:0], so_oe};
            sck = 1'b1;
            tick(H);
        end
    endtask

    task automatic xfer(input bit m3, input logic [7:0] tx[10], input int n, input int tail,
                        output logic [7:0] rx[10], output logic [7:0] oe[10]);
        logic [7:0] dq, doe;
        sel_begin(m3);
        for (int i = 0; i < n; i++) bits(tx[i], 8, rx[i], oe[i]);
        if (tail > 0) bits(tx[n], tail, dq, doe);
        sel_end(m3);
    endtask

    task automatic do_write(input bit m3, input logic [15:0] addr, input logic [7:0] d[4],
                            input int n, input int tail, input string tag);
        logic [7:0] tx[10], rx[10], oe[10];
        logic [13:0] a;
        tx = '{default: 8'h00};
        tx[0] = 8'h02; tx[1] = addr[15:8]; tx[2] = addr[7:0];
        for (int k = 0; k < 4; k++) tx[3+k] = d[k];
        for (int k = 0; k < n; k++) begin
            a = addr[13:0] + 14'(k);
            if ({1'b0, a} < prot_limit) begin
                expect_ev(8'd5, {2'b00, a}, d[k], tag);
                golden[a] = d[k];
            end
        end
        xfer(m3, tx, 3 + n, tail, rx, oe);
        check({tag, " so_oe low during write (R5)"}, {24'd0, oe[3]}, 32'd0);
    endtask

    task automatic do_read(input bit m3, input logic [15:0] addr, input int n, input string tag);
        logic [7:0] tx[10], rx[10], oe[10];
        logic [13:0] a;
        tx = '{default: 8'h00};
        tx[0] = 8'h03; tx[1] = addr[15:8]; tx[2] = addr[7:0];
        xfer(m3, tx, 3 + n, 0, rx, oe);
        check({tag, " so_oe low in address phase (R5)"}, {24'd0, oe[2]}, 32'd0);
        for (int k = 0; k < n; k++) begin
            a = addr[13:0] + 14'(k);
            check(tag, {18'd0, a, rx[3+k]}, {18'd0, a, golden[a]});
            check({tag, " so_oe during data"}, {24'd0, oe[3+k]}, 32'hFF);
        end
    endtask

    task automatic one_cmd(input bit m3, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input int n, input int tail,
                           output logic [7:0] rx[10], output logic [7:0] oe[10]);
        logic [7:0] tx[10];
        tx = '{default: 8'h00};
        tx[0] = b0; tx[1] = b1; tx[2] = b2;
        xfer(m3, tx, n, tail, rx, oe);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rx[10], oe[10], q1, q2, o1, o2;
        logic [7:0] wd[4];
        for (int i = 0; i < DEPTH; i++) begin
            ram[i]    = 8'(i) ^ 8'hA5 ^ 8'(i >> 6);
            golden[i] = ram[i];
        end
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
        status_in = 8'h8C; sr_wr_allow = 1'b1; prot_limit = 15'h4000;
        tick(10);
        check("R5 reset so_oe", {31'd0, so_oe}, 32'd0);
        check("R4 reset mem_we", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        tick(10);

        // R1 and R10: single-byte commands in both clock idle levels.
        expect_ev(8'd1, 16'd0, 8'd0, "R1 wel_set mode0");
        one_cmd(1'b0, 8'h06, 8'h00, 8'h00, 1, 0, rx, oe);
        check("R5 so_oe during command", {24'd0, oe[0]}, 32'd0);
        expect_ev(8'd2, 16'd0, 8'd0, "R1 R10 wel_clr mode3");
        one_cmd(1'b1, 8'h04, 8'h00, 8'h00, 1, 0, rx, oe);
        expect_ev(8'd3, 16'd0, 8'd0, "R1 sleep");
        one_cmd(1'b0, 8'hB9, 8'h00, 8'h00, 1, 0, rx, oe);
        expect_ev(8'd4, 16'd0, 8'd0, "R1 R10 wake mode3");
        one_cmd(1'b1, 8'hAB, 8'h00, 8'h00, 1, 0, rx, oe);

        // R6: extra bytes after a command, and an unknown opcode.
        expect_ev(8'd1, 16'd0, 8'd0, "R6 only first command");
        one_cmd(1'b0, 8'h06, 8'h04, 8'hB9, 3, 0, rx, oe);
        one_cmd(1'b0, 8'h5A, 8'h03, 8'h00, 3, 0, rx, oe);
        check("R6 unknown opcode so_oe", {8'd0, oe[0], oe[1], oe[2]}, 32'd0);

        // R2 R4: write with top address bits set, read back in mode 3.
        wd = '{8'h11, 8'h22, 8'h33, 8'h00};
        do_write(1'b0, 16'hC010, wd, 3, 0, "R4 write stream");
        do_read(1'b1, 16'h4010, 3, "R2 R10 read stream mode3");

        // R3: wrap in both streams.
        wd = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
        do_write(1'b1, 16'h3FFE, wd, 4, 0, "R3 write wrap");
        do_read(1'b0, 16'h3FFE, 4, "R3 read wrap");

        // R4: partial trailing byte is discarded.
        wd = '{8'h5C, 8'hC5, 8'h00, 8'h00};
        do_write(1'b0, 16'h0100, wd, 1, 5, "R4 partial byte");
        do_read(1'b0, 16'h0100, 2, "R4 partial byte readback");

        // R4: protection refuses addresses at and above the limit.
        prot_limit = 15'h2000;
        wd = '{8'h77, 8'h88, 8'h00, 8'h00};
        do_write(1'b0, 16'h1FFF, wd, 2, 0, "R4 protected write");
        prot_limit = 15'h4000;
        do_read(1'b0, 16'h1FFF, 2, "R4 protected readback");

        // R8: status read, two byte periods, both modes.
        one_cmd(1'b0, 8'h05, 8'h00, 8'h00, 3, 0, rx, oe);
        check("R8 status byte", {16'd0, rx[1], oe[1]}, {16'd0, 8'h8C, 8'hFF});
        check("R8 status repeat", {24'd0, rx[2]}, 32'h8C);
        status_in = 8'h43;
        one_cmd(1'b1, 8'h05, 8'h00, 8'h00, 2, 0, rx, oe);
        check("R8 R10 status mode3", {24'd0, rx[1]}, 32'h43);

        // R9: status writes: permitted, refused, partial.
        expect_ev(8'd6, 16'd0, 8'h3C, "R9 status write");
        one_cmd(1'b0, 8'h01, 8'h3C, 8'h00, 2, 0, rx, oe);
        sr_wr_allow = 1'b0;
        one_cmd(1'b0, 8'h01, 8'h99, 8'h00, 2, 0, rx, oe);
        sr_wr_allow = 1'b1;
        one_cmd(1'b1, 8'h01, 8'hF0, 8'h00, 1, 4, rx, oe);
        tick(4);
        check("R9 no status write when refused or partial", exp_q.size(), 32'd0);

        // R7: hold in the middle of a read byte, with SCK and CS activity.
        sel_begin(1'b0);
        bits(8'h03, 8, q1, o1);
        bits(8'h02, 8, q1, o1);
        bits(8'h00, 8, q1, o1);
        bits(8'h00, 4, q1, o1);
        sck = 1'b0;
        tick(H);
        hold_n = 1'b0;
        tick(6);
        check("R7 R5 so_oe low during hold", {31'd0, so_oe}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; si = ~si; tick(3);
            sck = 1'b0; tick(3);
        end
        cs_n = 1'b1; tick(5); cs_n = 1'b0; tick(5);
        hold_n = 1'b1;
        tick(6);
        bits(8'h00, 4, q2, o2);
        check("R7 byte resumes after hold", {24'd0, q1[3:0], q2[3:0]}, {24'd0, golden[14'h0200]});
        check("R7 so_oe after hold", {24'd0, o1[3:0], o2[3:0]}, 32'hFF);
        bits(8'h00, 8, q2, o2);
        check("R7 R3 next byte after hold", {24'd0, q2}, {24'd0, golden[14'h0201]});
        sel_end(1'b0);
        check("R5 so_oe after deselect", {31'd0, so_oe}, 32'd0);

        tick(20);
        check("R1 R4 R9 all expected events seen", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule